// File: doc/BRIEF.md
# I2C Target Responder with Request Status

This block is an I2C bus target with a 7-bit own address. It serves one byte at a time through a data register and reports each request through a status register. Both bus lines are open-drain, so the block only ever pulls them low, through the `scl_oe` and `sda_oe` outputs. SCL and SDA are brought into the clock domain through two-flop synchronizers. START is an SDA fall while SCL is high, and STOP is an SDA rise while SCL is high.

When the master addresses the block, the block acknowledges. It then holds SCL low until software answers each byte.

- **Master write:** each received byte is acknowledged. The byte is placed in the data register as a receive request, and SCL stays low until software reads it.
- **Master read:** the block raises a transmit request and holds SCL low until software writes a byte. It then shifts that byte out MSB first.
- **Interrupts:** DATA, START and STOP events set raw interrupt bits. These are gated by a mask and combined into a single `irq` line.

Software reaches the block through a simple register port. Reads are combinational. A read of the data register counts as servicing a receive request.

Register map (`reg_addr`):

| Address | Read | Write |
|---|---|---|
| 0 | own address in bits 6:0 | own address in bits 6:0 |
| 1 | enable in bit 0 | enable in bit 0 |
| 2 | status | (no write) |
| 3 | data | data |
| 4 | mask | sets mask bits written as 1 |
| 5 | raw interrupt bits | clears mask bits written as 1 |
| 6 | masked interrupt bits | clears raw bits written as 1 |

Top module: `i2c_target_resp`

## Requirements
- R1: After the address byte, the block pulls SDA low during the ninth clock only if the 7 address bits equal the own address. A non-matching address leaves SDA released, the status at 0, and the block idle until the next START.
- R2: On a master write, each received byte is loaded into the data register (read at address 3). The status reads 0x5 (receive request 0x1 plus first-byte flag 0x4) for the first byte after the address and 0x1 for later bytes.
- R3: While a receive request is pending, the block holds SCL low after the ACK clock. It releases SCL once the data register is read, which also clears the status to 0.
- R4: On a master read, the status reads 0x2 and SCL is held low until the data register is written. The written byte then goes out MSB first, and the status returns to 0 on the write.
- R5: After the master NACKs a transmitted byte, the block releases SDA, raises no further transmit request (status stays 0), and waits for STOP or START.
- R6: The raw interrupt bits (read at address 5) are set by events. DATA (bit 0) is set whenever a request is posted, START (bit 1) on a START, and STOP (bit 2) on a STOP. Events are recorded only while the block is enabled.
- R7: Writing 1s to address 4 sets mask bits and writing 1s to address 5 clears them. The masked bits (read at address 6) equal raw AND mask, and `irq` is high exactly when any masked bit is set.
- R8: Writing to address 6 clears the raw bits written as 1 and leaves the others. An event in the same cycle wins over the clear.
- R9: With enable (address 1, bit 0) at 0, the block drives neither line, does not acknowledge its own address, and records no events.
- R10: After reset the block is disabled, with own address 0, status 0, raw and mask bits 0, and `irq` low. Receive and transmit requests are never pending together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | Pulls SCL low when 1 (clock stretch) |
| sda_oe | output | 1 | Pulls SDA low when 1 (ACK or data 0) |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe (side effect on data read) |
| reg_addr | input | REG_AW | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| irq | output | 1 | Combined masked interrupt |

## Verification
The bench runs a bus master model that respects clock stretching. It drives transfers while a software thread polls the status register and services each request.

It checks the following corner cases:
- **Non-matching address:** a block that acknowledged it would read back as a 0 ACK bit.
- **Disabled block:** a disabled block that still answered would do the same, or would set raw bits.
- **First-byte flag:** the flag must appear only on the first byte after the address. A design that set it on every byte, or never, would show 0x1 and 0x5 swapped.
- **SCL hold while a receive request is pending:** if the block released SCL early, the line would read high.
- **Transmit byte order:** a reversed bit order would read back as the wrong byte.
- **Master NACK:** a block that ignored the NACK would post a new transmit request and stretch the clock again.
- **Partial interrupt clear:** a clear that wiped every raw bit would show up as the wrong raw value.

// File: rtl/i2c_tr_pkg.sv
package i2c_tr_pkg;
    localparam int BYTE_W  = 8;
    localparam int TADDR_W = 7;
    localparam int CNT_W   = $clog2(BYTE_W + 1);
    localparam int IRQ_N   = 3;

    // register addresses
    localparam int RA_OWN    = 0;
    localparam int RA_CTRL   = 1;
    localparam int RA_STATUS = 2;
    localparam int RA_DATA   = 3;
    localparam int RA_MSET   = 4;
    localparam int RA_MCLR   = 5;
    localparam int RA_ICLR   = 6;

    // interrupt bit positions
    localparam int IB_DATA  = 0;
    localparam int IB_START = 1;
    localparam int IB_STOP  = 2;

    typedef enum logic [3:0] {
        S_IDLE, S_ADDR, S_ADDR_ACK, S_RX_BITS, S_RX_ACK, S_RX_HOLD,
        S_TX_HOLD, S_TX_SETUP, S_TX_BITS, S_TX_ACK
    } tr_state_e;
endpackage

// File: rtl/i2c_tr_sync.sv
module i2c_tr_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    for (genvar g = 0; g < WIDTH; g++) begin : g_line
        logic [STAGES-1:0] chain_q;
        logic [STAGES-1:0] chain_d;
        always_comb chain_d = {chain_q[STAGES-2:0], d_i[g]};
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= chain_d;
        end
        assign q_o[g] = chain_q[STAGES-1];
    end
endmodule

// File: rtl/i2c_tr_cond.sv
module i2c_tr_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    typedef struct packed { logic scl; logic sda; } prev_t;
    prev_t prev_d, prev_q;

    always_comb begin
        prev_d.scl = scl_s;
        prev_d.sda = sda_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '{scl: 1'b1, sda: 1'b1};
        else        prev_q <= prev_d;
    end

    assign scl_rise  = scl_s & ~prev_q.scl;
    assign scl_fall  = ~scl_s & prev_q.scl;
    assign start_det = scl_s & prev_q.scl & prev_q.sda & ~sda_s;
    assign stop_det  = scl_s & prev_q.scl & ~prev_q.sda & sda_s;
endmodule

// File: rtl/i2c_tr_irq.sv
module i2c_tr_irq #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] ev,
    input  logic         mset_we,
    input  logic         mclr_we,
    input  logic         iclr_we,
    input  logic [N-1:0] wbits,
    output logic [N-1:0] raw,
    output logic [N-1:0] mask,
    output logic [N-1:0] masked,
    output logic         irq
);
    typedef struct packed { logic [N-1:0] raw; logic [N-1:0] mask; } irq_t;
    irq_t d, q;

    always_comb begin
        d = q;
        if (mset_we) d.mask = q.mask | wbits;
        if (mclr_we) d.mask = q.mask & ~wbits;
        if (iclr_we) d.raw  = q.raw & ~wbits;
        d.raw = d.raw | ev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign raw    = q.raw;
    assign mask   = q.mask;
    assign masked = q.raw & q.mask;
    assign irq    = |masked;
endmodule

// File: rtl/i2c_target_resp.sv
module i2c_target_resp
    import i2c_tr_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int REG_AW      = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_oe,
    output logic              sda_oe,
    input  logic              reg_we,
    input  logic              reg_re,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              irq
);
    typedef struct packed {
        tr_state_e          st;
        logic [BYTE_W-1:0]  sh;
        logic [CNT_W-1:0]   cnt;
        logic [BYTE_W-1:0]  data;
        logic [TADDR_W-1:0] own;
        logic               en;
        logic               rreq;
        logic               treq;
        logic               first;
        logic               fresh;
        logic               nack;
        logic               scl_oe;
        logic               sda_oe;
    } core_t;

    core_t d, q;

    logic [1:0] lines_s;
    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic [IRQ_N-1:0] ev, raw, mask, masked;

    i2c_tr_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i({scl_i, sda_i}), .q_o(lines_s));
    assign scl_s = lines_s[1];
    assign sda_s = lines_s[0];

    i2c_tr_cond u_cond (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det));

    wire wr_own  = reg_we && reg_addr == REG_AW'(RA_OWN);
    wire wr_ctrl = reg_we && reg_addr == REG_AW'(RA_CTRL);
    wire wr_data = reg_we && reg_addr == REG_AW'(RA_DATA);
    wire rd_data = reg_re && reg_addr == REG_AW'(RA_DATA);

    always_comb begin
        d  = q;
        ev = '0;
        if (wr_own)  d.own  = reg_wdata[TADDR_W-1:0];
        if (wr_ctrl) d.en   = reg_wdata[0];
        if (wr_data) d.data = reg_wdata;
        if (rd_data) begin
            d.rreq  = 1'b0;
            d.first = 1'b0;
        end

        unique case (q.st)
            S_ADDR: begin
                if (scl_rise) begin
                    d.sh  = {q.sh[BYTE_W-2:0], sda_s};
                    d.cnt = q.cnt + 1'b1;
                end else if (scl_fall && q.cnt == CNT_W'(BYTE_W)) begin
                    if (q.sh[BYTE_W-1:1] == q.own) begin
                        d.st     = S_ADDR_ACK;
                        d.sda_oe = 1'b1;
                        d.fresh  = 1'b1;
                    end else begin
                        d.st = S_IDLE;
                    end
                end
            end
            S_ADDR_ACK: if (scl_fall) begin
                d.sda_oe = 1'b0;
                d.cnt    = '0;
                if (q.sh[0]) begin
                    d.st          = S_TX_HOLD;
                    d.scl_oe      = 1'b1;
                    d.treq        = 1'b1;
                    ev[IB_DATA]   = 1'b1;
                end else begin
                    d.st = S_RX_BITS;
                end
            end
            S_RX_BITS: begin
                if (scl_rise) begin
                    d.sh  = {q.sh[BYTE_W-2:0], sda_s};
                    d.cnt = q.cnt + 1'b1;
                end else if (scl_fall && q.cnt == CNT_W'(BYTE_W)) begin
                    d.st     = S_RX_ACK;
                    d.sda_oe = 1'b1;
                end
            end
            S_RX_ACK: if (scl_fall) begin
                d.sda_oe    = 1'b0;
                d.scl_oe    = 1'b1;
                d.data      = q.sh;
                d.rreq      = 1'b1;
                d.first     = q.fresh;
                d.fresh     = 1'b0;
                d.cnt       = '0;
                d.st        = S_RX_HOLD;
                ev[IB_DATA] = 1'b1;
            end
            S_RX_HOLD: if (rd_data) begin
                d.scl_oe = 1'b0;
                d.st     = S_RX_BITS;
            end
            S_TX_HOLD: if (wr_data) begin
                d.sh     = reg_wdata;
                d.sda_oe = ~reg_wdata[BYTE_W-1];
                d.treq   = 1'b0;
                d.cnt    = '0;
                d.st     = S_TX_SETUP;
            end
            S_TX_SETUP: begin
                d.scl_oe = 1'b0;
                d.st     = S_TX_BITS;
            end
            S_TX_BITS: if (scl_fall) begin
                d.sh  = {q.sh[BYTE_W-2:0], 1'b0};
                d.cnt = q.cnt + 1'b1;
                if (q.cnt == CNT_W'(BYTE_W - 1)) begin
                    d.sda_oe = 1'b0;
                    d.st     = S_TX_ACK;
                end else begin
                    d.sda_oe = ~q.sh[BYTE_W-2];
                end
            end
            S_TX_ACK: begin
                if (scl_rise) d.nack = sda_s;
                else if (scl_fall) begin
                    if (q.nack) d.st = S_IDLE;
                    else begin
                        d.st        = S_TX_HOLD;
                        d.scl_oe    = 1'b1;
                        d.treq      = 1'b1;
                        ev[IB_DATA] = 1'b1;
                    end
                end
            end
            default: begin
                d.sda_oe = 1'b0;
                d.scl_oe = 1'b0;
            end
        endcase

        if (!q.en || start_det || stop_det) begin
            d.sda_oe = 1'b0;
            d.scl_oe = 1'b0;
            d.rreq   = 1'b0;
            d.treq   = 1'b0;
            d.first  = 1'b0;
            d.fresh  = 1'b0;
            d.st     = S_IDLE;
            ev       = '0;
            if (q.en && start_det) begin
                d.st         = S_ADDR;
                d.cnt        = '0;
                ev[IB_START] = 1'b1;
            end
            if (q.en && stop_det) ev[IB_STOP] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: S_IDLE, default: '0};
        else        q <= d;
    end

    i2c_tr_irq #(.N(IRQ_N)) u_irq (
        .clk(clk), .rst_n(rst_n), .ev(ev),
        .mset_we(reg_we && reg_addr == REG_AW'(RA_MSET)),
        .mclr_we(reg_we && reg_addr == REG_AW'(RA_MCLR)),
        .iclr_we(reg_we && reg_addr == REG_AW'(RA_ICLR)),
        .wbits(reg_wdata[IRQ_N-1:0]),
        .raw(raw), .mask(mask), .masked(masked), .irq(irq));

    always_comb begin
        unique case (int'(reg_addr))
            RA_OWN:    reg_rdata = {1'b0, q.own};
            RA_CTRL:   reg_rdata = {7'b0, q.en};
            RA_STATUS: reg_rdata = {5'b0, q.first, q.treq, q.rreq};
            RA_DATA:   reg_rdata = q.data;
            RA_MSET:   reg_rdata = {5'b0, mask};
            RA_MCLR:   reg_rdata = {5'b0, raw};
            RA_ICLR:   reg_rdata = {5'b0, masked};
            default:   reg_rdata = '0;
        endcase
    end

    assign scl_oe = q.scl_oe;
    assign sda_oe = q.sda_oe;

    // plain views for the bound checker
    logic en_v, rreq_v, treq_v, first_v;
    assign en_v    = q.en;
    assign rreq_v  = q.rreq;
    assign treq_v  = q.treq;
    assign first_v = q.first;
endmodule

// File: rtl/i2c_tr_chk.sv
module i2c_tr_chk #(
    parameter int REG_AW = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en,
    input logic              rreq,
    input logic              treq,
    input logic              first,
    input logic              scl_oe,
    input logic              sda_oe,
    input logic              reg_we,
    input logic [REG_AW-1:0] reg_addr,
    input logic [7:0]        reg_wdata,
    input logic [2:0]        ev,
    input logic [2:0]        raw
);
    AST_RREQ_STRETCH: assert property (@(posedge clk) disable iff (!rst_n)
        rreq |-> scl_oe); // R3
    AST_TREQ_STRETCH: assert property (@(posedge clk) disable iff (!rst_n)
        treq |-> scl_oe); // R4
    AST_FIRST_WITH_RREQ: assert property (@(posedge clk) disable iff (!rst_n)
        first |-> rreq); // R2
    AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(rreq && treq)); // R10
    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && $past(!en)) |-> (!sda_oe && !scl_oe)); // R9
    AST_CLEAR_START: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == REG_AW'(6) && reg_wdata[1] && !ev[1]) |=> !raw[1]); // R8
    AST_DATA_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        ev[0] |=> raw[0]); // R6
endmodule

bind i2c_target_resp i2c_tr_chk #(.REG_AW(REG_AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .en(en_v), .rreq(rreq_v), .treq(treq_v),
    .first(first_v), .scl_oe(scl_oe), .sda_oe(sda_oe), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .ev(ev), .raw(raw));

// File: tb/i2c_target_resp_tb.sv
module i2c_target_resp_tb;
    localparam int CLK_PERIOD = 10;
    localparam int H = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl_lo = 1'b0, m_sda_lo = 1'b0;
    logic scl_oe, sda_oe, irq;
    logic reg_we = 1'b0, reg_re = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0, reg_rdata;
    int checks = 0, fails = 0;

    wire scl_line = !(m_scl_lo || scl_oe);
    wire sda_line = !(m_sda_lo || sda_oe);

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_target_resp u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .reg_we(reg_we), .reg_re(reg_re),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq));

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // register port
    task automatic rd(input int a, output logic [7:0] v);
        @(negedge clk); reg_addr = 3'(a); reg_re = 1'b1; #1 v = reg_rdata;
        @(negedge clk); reg_re = 1'b0;
    endtask
    task automatic wr(input int a, input logic [7:0] v);
        @(negedge clk); reg_addr = 3'(a); reg_wdata = v; reg_we = 1'b1;
        @(negedge clk); reg_we = 1'b0;
    endtask
    task automatic poll_status(output logic [7:0] v);
        v = 0;
        for (int i = 0; i < 3000 && v == 0; i++) rd(2, v);
    endtask

    // bus master model
    task automatic hw(); repeat (H) @(negedge clk); endtask
    task automatic rel_scl();
        m_scl_lo = 1'b0;
        @(negedge clk);
        while (!scl_line) @(negedge clk);
    endtask
    task automatic m_start();
        m_sda_lo = 1'b1; hw(); m_scl_lo = 1'b1; hw();
    endtask
    task automatic m_rstart();
        m_sda_lo = 1'b0; hw(); rel_scl(); hw(); m_sda_lo = 1'b1; hw();
        m_scl_lo = 1'b1; hw();
    endtask
    task automatic m_stop();
        m_sda_lo = 1'b1; hw(); rel_scl(); hw(); m_sda_lo = 1'b0; hw();
    endtask
    task automatic wr_bit(input logic b);
        m_sda_lo = !b; hw(); rel_scl(); hw(); m_scl_lo = 1'b1; hw();
    endtask
    task automatic rd_bit(output logic b);
        m_sda_lo = 1'b0; hw(); rel_scl(); repeat (H/2) @(negedge clk);
        b = sda_line; repeat (H/2) @(negedge clk); m_scl_lo = 1'b1; hw();
    endtask
    task automatic wr_byte(input logic [7:0] v, output logic ack_n);
        for (int i = 7; i >= 0; i--) wr_bit(v[i]);
        rd_bit(ack_n);
    endtask
    task automatic rd_byte(output logic [7:0] v);
        for (int i = 7; i >= 0; i--) begin
            logic b;
            rd_bit(b);
            v[i] = b;
        end
    endtask

    // scenarios
    task automatic t_reset();
        logic [7:0] v;
        rd(2, v); chk("R10 status", v, 0);
        rd(5, v); chk("R10 raw", v, 0);
        rd(0, v); chk("R10 own", v, 0);
        rd(1, v); chk("R10 enable", v, 0);
        chk("R10 irq", irq, 0);
    endtask

    task automatic t_disabled();
        logic a; logic [7:0] v;
        wr(0, 8'h3A);
        m_start(); wr_byte({7'h3A, 1'b0}, a); m_stop();
        chk("R9 no ack when disabled", a, 1);
        rd(5, v); chk("R9 no events when disabled", v, 0);
    endtask

    task automatic t_mismatch();
        logic a; logic [7:0] v;
        wr(1, 8'h01);
        m_start(); wr_byte({7'h22, 1'b0}, a);
        chk("R1 mismatch not acked", a, 1);
        wr_bit(1'b1); wr_bit(1'b0);
        rd(2, v); chk("R1 mismatch status", v, 0);
        rd(5, v); chk("R6 start raw", v, 3'b010);
        m_stop();
        rd(5, v); chk("R6 stop raw", v, 3'b110);
        wr(6, 8'h02);
        rd(5, v); chk("R8 partial clear", v, 3'b100);
        wr(6, 8'h04);
        rd(5, v); chk("R8 full clear", v, 0);
    endtask

    task automatic t_write();
        logic a, a1, a2; logic [7:0] v;
        m_start(); wr_byte({7'h3A, 1'b0}, a);
        chk("R1 match acked", a, 0);
        fork
            begin
                wr_byte(8'hA5, a1);
                wr_byte(8'h3C, a2);
            end
            begin
                logic [7:0] s, dv;
                poll_status(s); chk("R2 first byte status", s, 5);
                repeat (40) @(negedge clk);
                chk("R3 SCL held while pending", scl_line, 0);
                rd(3, dv); chk("R2 first byte data", dv, 8'hA5);
                rd(2, s); chk("R3 status clears on read", s, 0);
                poll_status(s); chk("R2 later byte status", s, 1);
                rd(3, dv); chk("R2 later byte data", dv, 8'h3C);
            end
        join
        chk("R2 byte ack", {a1, a2}, 0);
        m_stop();
        rd(5, v); chk("R6 raw after write", v, 3'b111);
        wr(6, 8'h07);
    endtask

    task automatic t_read();
        logic a; logic [7:0] v1, v2, v;
        m_start(); wr_byte({7'h3A, 1'b1}, a);
        chk("R1 read address acked", a, 0);
        fork
            begin
                rd_byte(v1); wr_bit(1'b0);
                rd_byte(v2); wr_bit(1'b1);
            end
            begin
                logic [7:0] s;
                poll_status(s); chk("R4 transmit request", s, 2);
                repeat (40) @(negedge clk);
                chk("R4 SCL held until write", scl_line, 0);
                wr(3, 8'h96);
                rd(2, s); chk("R4 status clears on write", s, 0);
                poll_status(s); chk("R4 second transmit request", s, 2);
                wr(3, 8'h41);
            end
        join
        chk("R4 first byte MSB first", v1, 8'h96);
        chk("R4 second byte", v2, 8'h41);
        repeat (60) @(negedge clk);
        rd(2, v); chk("R5 no request after NACK", v, 0);
        chk("R5 SDA released after NACK", sda_line, 1);
        chk("R5 SCL not held after NACK", scl_oe, 0);
        m_stop();
    endtask

    task automatic t_rstart_mask();
        logic a; logic [7:0] v, s;
        wr(6, 8'h07);
        m_start(); wr_byte({7'h3A, 1'b0}, a);
        m_rstart(); wr_byte({7'h3A, 1'b1}, a);
        chk("R1 ack after repeated start", a, 0);
        fork
            begin rd_byte(v); wr_bit(1'b1); end
            begin poll_status(s); chk("R4 request after repeated start", s, 2); wr(3, 8'hC3); end
        join
        chk("R4 byte after repeated start", v, 8'hC3);
        m_stop();
        rd(5, v); chk("R6 raw after read", v, 3'b111);
        wr(4, 8'h01);
        rd(4, v); chk("R7 mask set", v, 1);
        rd(6, v); chk("R7 masked data", v, 1);
        chk("R7 irq on", irq, 1);
        wr(6, 8'h01);
        chk("R7 irq off after clear", irq, 0);
        rd(6, v); chk("R7 masked after clear", v, 0);
        wr(4, 8'h04);
        chk("R7 irq from stop", irq, 1);
        rd(6, v); chk("R7 masked stop", v, 3'b100);
        wr(5, 8'h05);
        rd(4, v); chk("R7 mask clear", v, 0);
        chk("R7 irq masked off", irq, 0);
        wr(1, 8'h00);
        m_start(); wr_byte({7'h3A, 1'b0}, a); m_stop();
        chk("R9 disabled again no ack", a, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        t_reset();
        t_disabled();
        t_mismatch();
        t_write();
        t_read();
        t_rstart_mask();
        summary();
    end
endmodule